// File: doc/BRIEF.md
# Multiplexed-Bus RAM and I/O Interface

This block is a bus slave for an 8-bit processor whose low address byte and data share one set of wires. When the address latch strobe falls, the block captures three things together: the byte on the bus as an address, the chip-select pin, and the memory/I/O select. Later read and write strobes act on whatever was captured in that latch cycle. If the captured select is low, the access goes to an internal 256 x 8 static RAM. If it is high, the access is passed to an external register file through a simple port. That register file holds the I/O ports, the command/status registers and the timer, none of which are part of this block.

Everything in the block runs on one system clock. The strobes are sampled on that clock. A write takes effect once, in the cycle its strobe becomes valid. A read turns on the bus drivers one cycle after the read strobe is seen. The bidirectional bus is split into an input byte, an output byte and an output enable, and the pad ring puts them together. A build parameter sets whether the chip-select pin is active high or active low.

Top module: `mbus_ram_io_slave`

## Requirements
- R1: The block captures the address from `bus_in` on the first clock edge at which `ale` is sampled low after being sampled high. Changes on `bus_in` after that edge do not move the access location, and `reg_addr` shows the captured address.
- R2: The chip-select state is captured on that same edge. Changes on `ce_pin` after that edge do not affect the accesses that follow, until the next latch.
- R3: When the captured `io_sel` is 0, reads and writes use the internal RAM at the captured address. A read returns the byte last written to that location.
- R4: When the captured `io_sel` is 1, a read drives `reg_rdata` onto `bus_out`, and the RAM is not touched.
- R5: `bus_oe` goes to 1 one clock after `rd_n` is sampled low while `wr_n` is high and the captured chip select is active. It returns to 0 one clock after `rd_n` is sampled high. While the captured chip select is inactive, `bus_oe` stays at 0.
- R6: A write is committed exactly once per strobe. The commit happens on the first clock edge at which `wr_n` is sampled low with the captured chip select active. Holding `wr_n` low for longer produces no further commit.
- R7: An I/O write raises `reg_wr` for exactly one cycle, in the cycle after the commit edge. During that cycle `reg_wdata` holds the bus byte sampled at the commit edge.
- R8: When `rd_n` and `wr_n` are both low, the cycle is a no-operation. `bus_oe` stays at 0, the RAM is not written and `reg_wr` stays at 0.
- R9: With the default `CE_ACTIVE_HIGH = 0`, the chip is selected when `ce_pin` is 0 at the latch edge. When it is not selected, writes change neither the RAM nor the register port.
- R10: While `rst` is high and after it is released, `bus_oe`, `reg_wr` and `reg_rd` are 0 and the captured chip select is inactive. A read issued with no new latch cycle after reset does not drive the bus.
- R11: An I/O read raises `reg_rd` for exactly one cycle, in the same cycle that `bus_oe` rises. A RAM read never raises `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address latch strobe; capture on its falling edge |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ce_pin | input | 1 | Chip select; polarity set by parameter |
| io_sel | input | 1 | 0 selects RAM, 1 selects register space |
| bus_in | input | 8 | Incoming byte from the shared bus |
| bus_out | output | 8 | Read data toward the shared bus |
| bus_oe | output | 1 | Drive enable for the shared bus |
| reg_addr | output | 8 | Captured address toward the register file |
| reg_wdata | output | 8 | Write data toward the register file |
| reg_wr | output | 1 | One-cycle register write pulse |
| reg_rd | output | 1 | One-cycle register read pulse |
| reg_rdata | input | 8 | Read data from the register file |

## Verification
Each result has its own due cycle, counted in clock edges from the stimulus:
- The latched address and chip select are in effect after the first edge that sees `ale` low.
- A RAM write takes effect at the commit edge.
- `reg_wr` and `reg_wdata` are due one edge after the commit.
- `bus_oe`, `bus_out` and `reg_rd` are due one edge after `rd_n` falls.
- `bus_oe` drops one edge after `rd_n` rises.

The bench drives inputs on falling clock edges and samples on the next falling edge, so each check lands half a period after the edge its result depends on. It then samples once more on the following falling edge to confirm that the one-cycle pulses have ended. Latch inputs are scrambled right after the capture edge, so any leak from the live pins into a later access shows up as a miscompare.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
   typedef enum logic {
      TGT_RAM = 1'b0,
      TGT_IO  = 1'b1
   } target_e;
endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
   parameter int ADDR_W         = 8,
   parameter int BUS_W          = 8,
   parameter bit CE_ACTIVE_HIGH = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ale,
   input  logic                 ce_pin,
   input  logic                 io_sel,
   input  logic [BUS_W-1:0]     bus_in,
   output logic [ADDR_W-1:0]    addr_o,
   output logic                 sel_o,
   output mbus_pkg::target_e    tgt_o
);
   import mbus_pkg::*;

   if (ADDR_W > BUS_W) begin : g_bad_width
      $error("mbus_addr_latch: ADDR_W must not exceed BUS_W");
   end

   logic ale_q;
   logic ce_hit;
   logic capture;

   if (CE_ACTIVE_HIGH) begin : g_ce_high
      assign ce_hit = ce_pin;
   end else begin : g_ce_low
      assign ce_hit = ~ce_pin;
   end

   assign capture = ale_q & ~ale;

   always_ff @(posedge clk) begin
      if (rst) begin
         ale_q  <= 1'b0;
         addr_o <= '0;
         sel_o  <= 1'b0;
         tgt_o  <= TGT_RAM;
      end else begin
         ale_q <= ale;
         if (capture) begin
            addr_o <= bus_in[ADDR_W-1:0];
            sel_o  <= ce_hit;
            tgt_o  <= target_e'(io_sel);
         end
      end
   end

   // R1
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(ale_q && !ale) |=> $stable(addr_o));

   // R2
   sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(ale_q && !ale) |=> ($stable(sel_o) && $stable(tgt_o)));

   // R10
   sel_reset_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !sel_o);
endmodule

// File: rtl/mbus_strobe_ctrl.sv
module mbus_strobe_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic rd_n,
   input  logic wr_n,
   input  logic sel,
   output logic rd_on,
   output logic rd_start,
   output logic wr_commit
);
   logic rd_act;
   logic wr_act;
   logic wr_q;

   assign rd_act    = ~rd_n & wr_n & sel;
   assign wr_act    = ~wr_n & rd_n & sel;
   assign wr_commit = wr_act & ~wr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_on    <= 1'b0;
         rd_start <= 1'b0;
         wr_q     <= 1'b0;
      end else begin
         rd_on    <= rd_act;
         rd_start <= rd_act & ~rd_on;
         wr_q     <= wr_act;
      end
   end

   // R8
   no_conflict_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_n && !wr_n) |=> !rd_on);

   // R6
   single_commit_chk: assert property (@(posedge clk) disable iff (rst)
      wr_commit |=> !wr_commit);

   // R5
   oe_cause_chk: assert property (@(posedge clk) disable iff (rst)
      rd_on |-> $past(!rd_n && sel));

   // R11
   rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      rd_start |=> !rd_start);
endmodule

// File: rtl/mbus_ram.sv
module mbus_ram #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W > 12) begin : g_bad_depth
      $error("mbus_ram: ADDR_W too large for an internal array");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/mbus_ram_io_slave.sv
module mbus_ram_io_slave #(
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 8,
   parameter bit CE_ACTIVE_HIGH = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ale,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              ce_pin,
   input  logic              io_sel,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   input  logic [DATA_W-1:0] reg_rdata
);
   import mbus_pkg::*;

   if (DATA_W < 1) begin : g_bad_data
      $error("mbus_ram_io_slave: DATA_W must be positive");
   end

   logic [ADDR_W-1:0] addr_l;
   logic              sel_l;
   target_e           tgt_l;
   logic              rd_on;
   logic              rd_start;
   logic              wr_commit;
   logic [DATA_W-1:0] ram_rdata;
   logic              ram_we;

   mbus_addr_latch #(
      .ADDR_W        (ADDR_W),
      .BUS_W         (DATA_W),
      .CE_ACTIVE_HIGH(CE_ACTIVE_HIGH)
   ) latch_i (
      .clk   (clk),
      .rst   (rst),
      .ale   (ale),
      .ce_pin(ce_pin),
      .io_sel(io_sel),
      .bus_in(bus_in),
      .addr_o(addr_l),
      .sel_o (sel_l),
      .tgt_o (tgt_l)
   );

   mbus_strobe_ctrl strobe_i (
      .clk      (clk),
      .rst      (rst),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .sel      (sel_l),
      .rd_on    (rd_on),
      .rd_start (rd_start),
      .wr_commit(wr_commit)
   );

   assign ram_we = wr_commit & (tgt_l == TGT_RAM);

   mbus_ram #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) ram_i (
      .clk  (clk),
      .we   (ram_we),
      .addr (addr_l),
      .wdata(bus_in),
      .rdata(ram_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         reg_wr    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_wr <= wr_commit & (tgt_l == TGT_IO);
         if (wr_commit && tgt_l == TGT_IO) begin
            reg_wdata <= bus_in;
         end
      end
   end

   assign reg_addr = addr_l;
   assign reg_rd   = rd_start & (tgt_l == TGT_IO);
   assign bus_oe   = rd_on;
   assign bus_out  = (tgt_l == TGT_IO) ? reg_rdata : ram_rdata;

   // R7
   reg_wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      reg_wr |=> !reg_wr);

   // R4
   no_ram_on_io_chk: assert property (@(posedge clk) disable iff (rst)
      (tgt_l == TGT_IO) |-> !ram_we);

   // R10
   reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!bus_oe && !reg_wr && !reg_rd));

   // R11
   rd_pulse_with_oe_chk: assert property (@(posedge clk) disable iff (rst)
      reg_rd |-> (bus_oe && !$past(bus_oe)));
endmodule

// File: tb/mbus_ram_io_slave_tb.sv
`timescale 1ns/1ps
module mbus_ram_io_slave_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ale = 1'b0;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic       ce_pin = 1'b1;
   logic       io_sel = 1'b0;
   logic [7:0] bus_in = 8'h00;
   logic [7:0] bus_out;
   logic       bus_oe;
   logic [7:0] reg_addr;
   logic [7:0] reg_wdata;
   logic       reg_wr;
   logic       reg_rd;
   logic [7:0] reg_rdata;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   // external register file model: a read returns address xor A5
   assign reg_rdata = reg_addr ^ 8'hA5;

   mbus_ram_io_slave dut_i (
      .clk      (clk),
      .rst      (rst),
      .ale      (ale),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .ce_pin   (ce_pin),
      .io_sel   (io_sel),
      .bus_in   (bus_in),
      .bus_out  (bus_out),
      .bus_oe   (bus_oe),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_wr   (reg_wr),
      .reg_rd   (reg_rd),
      .reg_rdata(reg_rdata)
   );

   // {io, addr, data}
   localparam logic [16:0] VEC [8] = '{
      {1'b0, 8'h00, 8'h3C},
      {1'b0, 8'hFF, 8'hC3},
      {1'b1, 8'h10, 8'h5A},
      {1'b0, 8'h55, 8'h01},
      {1'b1, 8'hFE, 8'hE7},
      {1'b0, 8'hAA, 8'h80},
      {1'b0, 8'h7F, 8'hFF},
      {1'b1, 8'h02, 8'h00}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ce_lvl is the pin level; 0 selects with the default polarity
   task automatic do_latch(input logic io, input logic [7:0] a, input logic ce_lvl);
      @(negedge clk);
      ale = 1'b1; bus_in = a; io_sel = io; ce_pin = ce_lvl;
      @(negedge clk);
      ale = 1'b0;
      @(negedge clk);
      bus_in = ~a; io_sel = ~io; ce_pin = ~ce_lvl;
   endtask

   task automatic do_write(input logic io, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_in = d; wr_n = 1'b0;
      @(negedge clk);
      chk("R7 reg_wr", {7'd0, reg_wr}, {7'd0, io});
      if (io) begin
         chk("R7 reg_wdata", reg_wdata, d);
         chk("R1 reg_addr", reg_addr, a);
      end
      @(negedge clk);
      chk("R6 single commit", {7'd0, reg_wr}, 8'd0);
      wr_n = 1'b1; bus_in = ~d;
   endtask

   task automatic do_read(input logic io, input logic [7:0] exp, input string req);
      @(negedge clk);
      rd_n = 1'b0;
      @(negedge clk);
      chk("R5 oe on", {7'd0, bus_oe}, 8'd1);
      chk(req, bus_out, exp);
      chk("R11 reg_rd", {7'd0, reg_rd}, {7'd0, io});
      @(negedge clk);
      chk("R11 reg_rd end", {7'd0, reg_rd}, 8'd0);
      rd_n = 1'b1;
      @(negedge clk);
      chk("R5 oe off", {7'd0, bus_oe}, 8'd0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state while rst is high
      chk("R10 oe in reset", {7'd0, bus_oe}, 8'd0);
      chk("R10 reg_wr in reset", {7'd0, reg_wr}, 8'd0);
      rst = 1'b0;
      // R10 read with no latch cycle after reset: not selected
      @(negedge clk); rd_n = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R10 no drive after reset", {7'd0, bus_oe}, 8'd0);
      chk("R10 no reg_rd after reset", {7'd0, reg_rd}, 8'd0);
      rd_n = 1'b1;

      // table walk: writes then read-back (R3, R4)
      for (int i = 0; i < 8; i++) begin
         do_latch(VEC[i][16], VEC[i][15:8], 1'b0);
         do_write(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
      end
      for (int i = 0; i < 8; i++) begin
         do_latch(VEC[i][16], VEC[i][15:8], 1'b0);
         if (VEC[i][16])
            do_read(1'b1, VEC[i][15:8] ^ 8'hA5, "R4 io read");
         else
            do_read(1'b0, VEC[i][7:0], "R3 ram read");
      end

      // R1 / R2: pins scrambled after the latch edge (inside do_latch); read again
      do_latch(1'b0, 8'h55, 1'b0);
      @(negedge clk); bus_in = 8'h00; ce_pin = 1'b1;
      do_read(1'b0, 8'h01, "R1 R2 latched state held");

      // R9: not selected, write must not land in RAM nor the register port
      do_latch(1'b0, 8'h00, 1'b1);
      @(negedge clk); bus_in = 8'hEE; wr_n = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R9 no reg_wr unselected", {7'd0, reg_wr}, 8'd0);
      wr_n = 1'b1; rd_n = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R9 no drive unselected", {7'd0, bus_oe}, 8'd0);
      rd_n = 1'b1;
      do_latch(1'b1, 8'h33, 1'b1);
      @(negedge clk); bus_in = 8'h99; wr_n = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R9 no io write unselected", {7'd0, reg_wr}, 8'd0);
      wr_n = 1'b1;
      do_latch(1'b0, 8'h00, 1'b0);
      do_read(1'b0, 8'h3C, "R9 ram unchanged");

      // R8: both strobes low
      do_latch(1'b0, 8'hFF, 1'b0);
      @(negedge clk); bus_in = 8'h12; rd_n = 1'b0; wr_n = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R8 no drive on conflict", {7'd0, bus_oe}, 8'd0);
      rd_n = 1'b1; wr_n = 1'b1;
      do_read(1'b0, 8'hC3, "R8 ram unchanged");
      do_latch(1'b1, 8'h44, 1'b0);
      @(negedge clk); bus_in = 8'h21; rd_n = 1'b0; wr_n = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R8 no reg_wr on conflict", {7'd0, reg_wr}, 8'd0);
      chk("R8 no reg_rd on conflict", {7'd0, reg_rd}, 8'd0);
      rd_n = 1'b1; wr_n = 1'b1;

      // R6: long write strobe, count pulses
      do_latch(1'b1, 8'h66, 1'b0);
      begin
         int pulses = 0;
         @(negedge clk); bus_in = 8'h4D; wr_n = 1'b0;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (reg_wr) pulses++;
         end
         wr_n = 1'b1;
         chk("R6 one pulse on long strobe", 8'(pulses), 8'd1);
      end
      chk("R7 reg_wdata kept", reg_wdata, 8'h4D);

      // R10: reset drops the selection
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk); rst = 1'b0;
      rd_n = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R10 selection cleared", {7'd0, bus_oe}, 8'd0);
      rd_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule